// File: doc/BRIEF.md
# Round-Robin Sample Bank with Ramp Flag Encoders

The block keeps the most recent samples of an input stream in a fixed set of slots. Each new sample lands in the slot picked by a rotating one-hot write phase, and it stays there until that phase comes round again. No sample is ever shifted from one slot to another. Samples arrive over a valid/ready stream port. The port applies back-pressure (`smp_ready` low) for as long as an evaluation is running.

An evaluation turns every stored sample into a time. A start strobe clears one accumulator per slot. From the next clock on, each accumulator adds its slot's sample plus a constant bias on every cycle. The slot's flag goes high on the first cycle the total reaches a fixed threshold, so larger samples raise their flags sooner. A downstream comparison tree can then read the ordering of the samples from the order in which the flags rise. The evaluation ends when every flag is high or when a cycle limit runs out. A done level then holds until the next start.

Back-pressure rule: a sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high. A producer that sees `smp_ready` low must hold its data and valid until the handshake completes.

Top module: `ramp_sample_bank`

## Requirements
- R1: After reset all flags are low, `eval_done` is low, `smp_ready` is high, and the first accepted sample goes to slot 0.
- R2: Accepted samples fill slots 0, 1, ..., SLOTS-1 in turn and then wrap to slot 0. Slot i drives bit i of `flags`.
- R3: A stored sample stays unchanged until its own slot is written again. Writes to other slots leave it alone.
- R4: A start strobe that is sampled while `smp_ready` is high clears every flag and `eval_done` at that edge. Ramping begins on the following edge.
- R5: With increment inc = sample + BIAS, flag i goes high exactly ceil(THRESH/inc) edges after the accepted start edge, provided that count is at most TIMEOUT. Otherwise the flag stays low for that evaluation.
- R6: The constant BIAS is added to every slot's increment, including the increment of a zero sample.
- R7: Once a flag is high it stays high until the next accepted start.
- R8: `smp_ready` is low from the edge after an accepted start until the evaluation ends. A sample offered during that time is held off and is stored in the next slot once `smp_ready` returns.
- R9: `eval_done` rises one edge after all flags are high, or TIMEOUT edges after the start edge, whichever comes first. It then stays high until the next accepted start.
- R10: A start strobe is ignored while an evaluation is running.
- R11: Every sample in the range from floor((2^SMP_W-1)/10) up to 2^SMP_W-1 raises its flag before the cycle limit runs out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample can be accepted (low while ramping) |
| smp_data | input | SMP_W | Sample value, unsigned |
| eval_start | input | 1 | Start an evaluation |
| flags | output | SLOTS | Per-slot ramp flags |
| eval_done | output | 1 | Evaluation finished |

## Verification
The assertions assume that `eval_start` and a sample handshake never happen in the same cycle. The stimulus keeps the two apart, sending pushes only from tasks that run outside the start pulse. The assertions also assume the producer holds a refused sample steady, and the push task does this until it sees `smp_ready`. Using an odd multiplier, the sweeps visit each 8-bit sample value exactly once. They cover zero and tiny samples that hit the cycle limit as well as full-scale samples that flag early.

// File: rtl/ramp_pkg.sv
`timescale 1ns/1ps
package ramp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_DONE = 2'd2
  } ramp_state_e;
endpackage

// File: rtl/phase_ring.sv
`timescale 1ns/1ps
module phase_ring #(
  parameter int SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SLOTS-1:0] phase,
  output logic [SLOTS-1:0] wr_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= SLOTS'(1);
    else if (adv) phase <= {phase[SLOTS-2:0], phase[SLOTS-1]};
  end

  assign wr_en = phase & {SLOTS{adv}};
endmodule

// File: rtl/ramp_slot.sv
`timescale 1ns/1ps
module ramp_slot #(
  parameter int SMP_W  = 8,
  parameter int THRESH = 2550,
  parameter int BIAS   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SMP_W-1:0] wr_data,
  input  logic             clr,
  input  logic             run,
  output logic             flag
);
  localparam int INC_MAX = (1 << SMP_W) - 1 + BIAS;
  localparam int ACC_W   = $clog2(THRESH + INC_MAX + 1);

  logic [SMP_W-1:0] held;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (wr_en) held <= wr_data;
  end

  assign acc_nxt = acc + ACC_W'(held) + ACC_W'(BIAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      flag <= 1'b0;
    end else if (run && !flag) begin
      acc <= acc_nxt;
      if (acc_nxt >= ACC_W'(THRESH)) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/eval_sequencer.sv
`timescale 1ns/1ps
module eval_sequencer
  import ramp_pkg::*;
#(
  parameter int TIMEOUT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic all_flags,
  output logic clr,
  output logic run,
  output logic done
);
  localparam int TW = $clog2(TIMEOUT + 1);

  ramp_state_e    state;
  logic [TW-1:0]  timer;
  logic [TW-1:0]  timer_nxt;

  assign run       = (state == ST_RAMP);
  assign done      = (state == ST_DONE);
  assign clr       = start_req && !run;
  assign timer_nxt = timer + TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      timer <= '0;
    end else if (clr) begin
      state <= ST_RAMP;
      timer <= '0;
    end else if (run) begin
      timer <= timer_nxt;
      if (all_flags || timer_nxt == TW'(TIMEOUT)) state <= ST_DONE;
    end
  end
endmodule

// File: rtl/ramp_sample_bank.sv
`timescale 1ns/1ps
module ramp_sample_bank #(
  parameter int SLOTS   = 8,
  parameter int SMP_W   = 8,
  parameter int THRESH  = 2550,
  parameter int BIAS    = 0,
  parameter int TIMEOUT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             eval_start,
  output logic [SLOTS-1:0] flags,
  output logic             eval_done
);
  logic [SLOTS-1:0] wr_phase;
  logic [SLOTS-1:0] wr_en;
  logic             ramp_on;
  logic             ramp_clr;
  logic             accept;

  assign smp_ready = !ramp_on;
  assign accept    = smp_valid && smp_ready;

  phase_ring #(.SLOTS(SLOTS)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .phase (wr_phase),
    .wr_en (wr_en)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    ramp_slot #(.SMP_W(SMP_W), .THRESH(THRESH), .BIAS(BIAS)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[g]),
      .wr_data (smp_data),
      .clr     (ramp_clr),
      .run     (ramp_on),
      .flag    (flags[g])
    );
  end

  eval_sequencer #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (eval_start),
    .all_flags (&flags),
    .clr       (ramp_clr),
    .run       (ramp_on),
    .done      (eval_done)
  );
endmodule

// File: rtl/ramp_sample_bank_chk.sv
`timescale 1ns/1ps
module ramp_sample_bank_chk #(
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             eval_start,
  input logic [SLOTS-1:0] flags,
  input logic             eval_done,
  input logic [SLOTS-1:0] wr_phase
);
  function automatic logic [SLOTS-1:0] rot(input logic [SLOTS-1:0] p);
    return {p[SLOTS-2:0], p[SLOTS-1]};
  endfunction

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_phase) == 1);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (wr_phase == rot($past(wr_phase))));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_ready |=> $stable(wr_phase));

  // R8
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_ready |-> !eval_done);

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_start && smp_ready) |=> (flags == '0 && !eval_done));

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eval_start && smp_ready) |=> ((flags & $past(flags)) == $past(flags)));

  // R9
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && !eval_start) |=> eval_done);
endmodule

bind ramp_sample_bank ramp_sample_bank_chk #(.SLOTS(SLOTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .eval_start (eval_start),
  .flags      (flags),
  .eval_done  (eval_done),
  .wr_phase   (wr_phase)
);

// File: tb/ramp_sample_bank_tb.sv
`timescale 1ns/1ps
module ramp_sample_bank_tb;
  localparam int SLOTS   = 8;
  localparam int SMP_W   = 8;
  localparam int THRESH  = 2550;
  localparam int BIAS    = 5;
  localparam int TIMEOUT = 128;
  localparam int VMIN    = ((1 << SMP_W) - 1) / 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_valid = 1'b0;
  logic             smp_ready;
  logic [SMP_W-1:0] smp_data = '0;
  logic             eval_start = 1'b0;
  logic [SLOTS-1:0] flags;
  logic             eval_done;

  int nchk = 0;
  int nfail = 0;
  int slot_m[SLOTS];
  int wp = 0;

  always #5 clk = ~clk;

  ramp_sample_bank #(.SLOTS(SLOTS), .SMP_W(SMP_W), .THRESH(THRESH),
                     .BIAS(BIAS), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .eval_start(eval_start), .flags(flags),
    .eval_done(eval_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = SMP_W'(v);
    while (!smp_ready) @(negedge clk);
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    slot_m[wp] = v;
    wp = (wp + 1) % SLOTS;
  endtask

  task automatic run_eval(input string tag);
    int k[SLOTS];
    int first[SLOTS];
    int maxk, dexp, dseen, inc, expf;
    logic [SLOTS-1:0] mask;
    maxk = 0;
    mask = '0;
    for (int i = 0; i < SLOTS; i++) begin
      inc  = slot_m[i] + BIAS;
      k[i] = (inc == 0) ? TIMEOUT + 100 : (THRESH + inc - 1) / inc;
      if (k[i] > maxk) maxk = k[i];
      if (k[i] <= TIMEOUT) mask[i] = 1'b1;
      first[i] = -1;
    end
    dexp  = (maxk + 1 < TIMEOUT) ? maxk + 1 : TIMEOUT;
    dseen = -1;
    @(negedge clk);
    eval_start = 1'b1;
    @(posedge clk);
    #1;
    eval_start = 1'b0;
    chk(flags == '0, {"R4 flags clear ", tag}, int'(flags), 0);
    chk(!eval_done, {"R4 done clear ", tag}, int'(eval_done), 0);
    for (int n = 1; n <= dexp + 3; n++) begin
      @(posedge clk);
      #1;
      for (int i = 0; i < SLOTS; i++)
        if (first[i] < 0 && flags[i]) first[i] = n;
      if (dseen < 0 && eval_done) dseen = n;
    end
    for (int i = 0; i < SLOTS; i++) begin
      expf = (k[i] <= TIMEOUT) ? k[i] : -1;
      chk(first[i] == expf,
          $sformatf("R2 R5 R6%s slot %0d value %0d %s",
                    (slot_m[i] >= VMIN) ? " R11" : "", i, slot_m[i], tag),
          first[i], expf);
    end
    chk(dseen == dexp, {"R9 done cycle ", tag}, dseen, dexp);
    chk(flags == mask, {"R7 flags held ", tag}, int'(flags), int'(mask));
    chk(eval_done, {"R9 done held ", tag}, int'(eval_done), 1);
  endtask

  initial begin
    #(200000 * 10);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) slot_m[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(flags == '0, "R1 flags", int'(flags), 0);
    chk(!eval_done, "R1 done", int'(eval_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_ready, "R1 ready", int'(smp_ready), 1);

    // Exhaustive value sweep: every 8-bit value once
    for (int e = 0; e < 32; e++) begin
      for (int i = 0; i < SLOTS; i++) push(((e * 8 + i) * 37) & 255);
      run_eval($sformatf("sweep %0d", e));
    end

    // R3 partial overwrite keeps older slots
    push(200); push(100); push(50);
    run_eval("R3 partial");

    // R8 hold-off during ramp
    fork
      run_eval("R8 busy");
      begin
        repeat (5) @(negedge clk);
        chk(!smp_ready, "R8 ready low in ramp", int'(smp_ready), 0);
        push(77);
      end
    join
    run_eval("R8 held sample landed");

    // R10 start ignored mid-ramp
    for (int i = 0; i < SLOTS; i++) push((i == 2) ? 0 : 30 + i * 20);
    fork
      run_eval("R10 restart ignored");
      begin
        repeat (20) @(negedge clk);
        eval_start = 1'b1;
        @(negedge clk);
        eval_start = 1'b0;
      end
    join

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule